// File: doc/BRIEF.md
# Double-Precision Funnel Shifter

This unit shifts a destination operand left or right and fills the vacated bit positions from a second, source operand rather than with zeros. It works at the full operand width or at half width, selected per operation. The count is 5 bits wide. At half width, counts beyond the half width are handled by a fixed concatenation rule.

A start strobe hands the unit one operation. The unit returns the result and an updated flag vector a fixed three cycles later, marked by a one-cycle done pulse. The carry, zero, sign and parity flags are recomputed from the result. The overflow flag is carried through from the flag input. Operand fetch, writeback and instruction decode belong to the surrounding datapath. A start that arrives while an operation is in flight is dropped.

Flag vector layout, used on both `flags_in` and `flags_out`:
- bit 0: carry
- bit 1: parity
- bit 2: zero
- bit 3: sign
- bit 4: overflow

Top module: `funnel_shifter`

## Requirements
- R1: Full-width left shift by n (1..31) returns `(dest << n) | (src >> (32 - n))`, so the low n bits hold the top n bits of `src`.
- R2: Full-width right shift by n (1..31) returns `(dest >> n) | (src << (32 - n))`, so the high n bits hold the low n bits of `src`.
- R3: Carry (flags_out bit 0) is the last bit shifted out of `dest`.
  - Left: bit (width - n) of the original `dest`.
  - Right: bit (n - 1) of the original `dest`.
- R4: Half-width left shift builds the 32-bit value V = {dest[15:0], src[15:0]} and returns bits [31:16] of (V << n) truncated to 32 bits.
  - For n of 16 or less, this equals V >> (16 - n).
  - For n above 16, carry is 0.
- R5: Half-width right shift returns the low 16 bits of {src[15:0], dest[15:0]} >> n.
  - For n above 16, carry is 0.
  - In half-width mode, result bits [31:16] are always 0.
- R6: With a count of 0:
  - `result` equals `dest`, with the upper half cleared in half-width mode.
  - `flags_out` equals `flags_in` unchanged.
- R7: The zero, sign and parity flags are computed from the result at the selected width.
  - Zero (bit 2) is set when the result is 0.
  - Sign (bit 3) is the result's top bit.
  - Parity (bit 1) is set when result bits [7:0] hold an even number of ones.
- R8: The overflow flag (bit 4) in `flags_out` always equals `flags_in` bit 4 as sampled at the accepted start.
- R9: A start accepted at clock edge E produces `done` high for exactly the one cycle that follows edge E+3, with the new `result` and `flags_out`.
- R10: `result` and `flags_out` hold their values between completions. A start asserted while an operation is in flight is ignored and produces no second done.
- R11: After reset, `done`, `result` and `flags_out` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation with the operands present this cycle |
| shift_right | input | 1 | 1 = shift right, 0 = shift left |
| wide | input | 1 | 1 = full 32-bit width, 0 = 16-bit width |
| count | input | 5 | Shift count |
| dest | input | 32 | Operand that is shifted |
| src | input | 32 | Operand that supplies the fill bits |
| flags_in | input | 5 | Incoming flag vector |
| result | output | 32 | Shifted value |
| flags_out | output | 5 | Updated flag vector |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the unit with its default width of 32, so one instance covers both the full-width path and the 16-bit half-width path. The 5-bit count lets it reach every shift amount, including the half-width counts 17 to 31 that fall under the concatenation rule and force carry to 0. Directed operations also cover count 0, 16 and 31, results that are exactly zero or negative, both parity outcomes, and a start issued while the unit is busy.

// File: rtl/funnel_shifter.sv
module funnel_shifter #(
  parameter int W = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic                 shift_right,
  input  logic                 wide,
  input  logic [$clog2(W)-1:0] count,
  input  logic [W-1:0]         dest,
  input  logic [W-1:0]         src,
  input  logic [4:0]           flags_in,
  output logic [W-1:0]         result,
  output logic [4:0]           flags_out,
  output logic                 done
);
  localparam int H   = W / 2;
  localparam int CW  = $clog2(W);
  localparam int LAT = 3;

  logic [W-1:0]   d_q, s_q;
  logic           r_q, w_q;
  logic [CW-1:0]  n_q;
  logic [4:0]     f_q;
  logic           busy;
  logic [1:0]     stg;

  logic [2*W-1:0] cat_l, cat_r, sh_l, sh_r;
  logic [W-1:0]   dmask, res_c;
  logic           cf_c, zf_c, sf_c, pf_c;
  int             idx;

  always_comb begin
    cat_l = w_q ? {d_q, s_q} : {{W{1'b0}}, d_q[H-1:0], s_q[H-1:0]};
    cat_r = w_q ? {s_q, d_q} : {{W{1'b0}}, s_q[H-1:0], d_q[H-1:0]};
    sh_l  = cat_l << n_q;
    sh_r  = cat_r >> n_q;
    dmask = w_q ? d_q : {{H{1'b0}}, d_q[H-1:0]};
    idx   = 0;
    cf_c  = f_q[0];
    res_c = dmask;
    if (n_q != '0) begin
      if (r_q) begin
        res_c = w_q ? sh_r[W-1:0] : {{H{1'b0}}, sh_r[H-1:0]};
        idx   = int'(n_q) - 1;
        cf_c  = (!w_q && int'(n_q) > H) ? 1'b0 : dmask[idx];
      end else begin
        res_c = w_q ? sh_l[2*W-1:W] : {{H{1'b0}}, sh_l[W-1:H]};
        idx   = w_q ? (W - int'(n_q)) : (H - int'(n_q));
        cf_c  = (!w_q && int'(n_q) > H) ? 1'b0 : dmask[idx];
      end
    end
    zf_c = w_q ? (res_c == '0) : (res_c[H-1:0] == '0);
    sf_c = w_q ? res_c[W-1] : res_c[H-1];
    pf_c = ~^res_c[7:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      d_q <= '0; s_q <= '0; r_q <= 1'b0; w_q <= 1'b0; n_q <= '0; f_q <= '0;
      busy <= 1'b0; stg <= '0; done <= 1'b0; result <= '0; flags_out <= '0;
    end else begin
      done <= 1'b0;
      if (start && !busy) begin
        d_q  <= dest;
        s_q  <= src;
        r_q  <= shift_right;
        w_q  <= wide;
        n_q  <= count;
        f_q  <= flags_in;
        busy <= 1'b1;
        stg  <= '0;
      end else if (busy) begin
        if (stg == 2'(LAT - 1)) begin
          busy   <= 1'b0;
          done   <= 1'b1;
          result <= res_c;
          if (n_q == '0) flags_out <= f_q;
          else           flags_out <= {f_q[4], sf_c, zf_c, pf_c, cf_c};
        end else begin
          stg <= stg + 2'd1;
        end
      end
    end
  end

  // R9
  done_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(start && !busy, 4));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(result) && $stable(flags_out)));

  // R5
  half_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !w_q) |-> (result[W-1:H] == '0));

  // R4
  half_big_count_cf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !w_q && (int'(n_q) > H)) |-> !flags_out[0]);

  // R8
  of_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (flags_out[4] == $past(flags_in[4], 4)));
endmodule

// File: tb/funnel_shifter_bench.sv
module funnel_shifter_bench;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        shift_right = 1'b0;
  logic        wide = 1'b1;
  logic [4:0]  count = '0;
  logic [31:0] dest = '0;
  logic [31:0] src = '0;
  logic [4:0]  flags_in = '0;
  logic [31:0] result;
  logic [4:0]  flags_out;
  logic        done;

  int checks = 0;
  int errors = 0;
  bit ended = 0;

  funnel_shifter u_funnel_shifter (
    .clk(clk), .rst_n(rst_n), .start(start), .shift_right(shift_right),
    .wide(wide), .count(count), .dest(dest), .src(src), .flags_in(flags_in),
    .result(result), .flags_out(flags_out), .done(done)
  );

  always #(PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic void model(input bit right, input bit wd, input int n,
                                input logic [31:0] d, input logic [31:0] s,
                                input logic [4:0] fi,
                                output logic [31:0] r, output logic [4:0] fo);
    int w = wd ? 32 : 16;
    logic [31:0] m = wd ? 32'hffffffff : 32'h0000ffff;
    logic [31:0] cur = d & m;
    logic [63:0] v;
    logic cf = 1'b0;
    int ones = 0;
    if (n == 0) begin
      r = cur; fo = fi; return;
    end
    if (wd || n <= 16) begin
      for (int k = 0; k < n; k++) begin
        if (!right) begin
          cf  = cur[w-1];
          cur = ((cur << 1) | 32'(s[w-1-k])) & m;
        end else begin
          cf  = cur[0];
          cur = ((cur >> 1) | (32'(s[k]) << (w-1))) & m;
        end
      end
      r = cur;
    end else if (!right) begin
      v = {32'h0, d[15:0], s[15:0]};
      v = (v << n) & 64'hffffffff;
      r = 32'(v >> 16) & 32'hffff;
    end else begin
      v = {32'h0, s[15:0], d[15:0]};
      r = 32'(v >> n) & 32'hffff;
    end
    for (int k = 0; k < 8; k++) ones += int'(r[k]);
    fo[0] = cf;
    fo[1] = (ones % 2) == 0;
    fo[2] = (r == 0);
    fo[3] = r[w-1];
    fo[4] = fi[4];
  endfunction

  task automatic run_op(input string req, input bit right, input bit wd, input int n,
                        input logic [31:0] d, input logic [31:0] s, input logic [4:0] fi);
    logic [31:0] er;
    logic [4:0]  ef;
    model(right, wd, n, d, s, fi, er, ef);
    @(negedge clk);
    start = 1'b1; shift_right = right; wide = wd; count = 5'(n);
    dest = d; src = s; flags_in = fi;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    chk(done == 1'b0, "R9 early", 32'(done), 0);
    @(posedge clk);
    @(negedge clk);
    chk(done == 1'b1, "R9 done", 32'(done), 1);
    chk(result == er, req, result, er);
    chk(flags_out == ef, {req, " flags"}, 32'(flags_out), 32'(ef));
    @(negedge clk);
    chk(done == 1'b0, "R9 pulse", 32'(done), 0);
    chk(result == er && flags_out == ef, "R10 hold", result, er);
  endtask

  task automatic t_reset();
    chk(done == 1'b0, "R11 done", 32'(done), 0);
    chk(result == 0, "R11 result", result, 0);
    chk(flags_out == 0, "R11 flags", 32'(flags_out), 0);
  endtask

  task automatic t_left32();
    run_op("R1 l32 n4",  0, 1, 4,  32'h8123_4567, 32'hA000_0000, 5'b00000);
    run_op("R1 l32 n31", 0, 1, 31, 32'h0000_0003, 32'hFFFF_FFFE, 5'b10000);
    run_op("R3 l32 n1",  0, 1, 1,  32'h8000_0000, 32'h0000_0000, 5'b00000);
  endtask

  task automatic t_right32();
    run_op("R2 r32 n8",  1, 1, 8,  32'h1234_5678, 32'h0000_00CD, 5'b00001);
    run_op("R2 r32 n31", 1, 1, 31, 32'hC000_0000, 32'h7FFF_FFFF, 5'b00000);
    run_op("R3 r32 n3",  1, 1, 3,  32'h0000_0004, 32'h0000_0000, 5'b00000);
  endtask

  task automatic t_left16();
    run_op("R4 l16 n5",  0, 0, 5,  32'hDEAD_9ABC, 32'hBEEF_F00F, 5'b00000);
    run_op("R4 l16 n16", 0, 0, 16, 32'h0000_0001, 32'h0000_8421, 5'b00000);
    run_op("R4 l16 n20", 0, 0, 20, 32'hFFFF_1234, 32'h1111_ABCD, 5'b00001);
    run_op("R4 l16 n31", 0, 0, 31, 32'h0000_FFFF, 32'h0000_FFFF, 5'b00000);
  endtask

  task automatic t_right16();
    run_op("R5 r16 n7",  1, 0, 7,  32'h5555_00FF, 32'hAAAA_0123, 5'b00000);
    run_op("R5 r16 n16", 1, 0, 16, 32'h0000_8000, 32'h0000_4321, 5'b00000);
    run_op("R5 r16 n25", 1, 0, 25, 32'h0000_FFFF, 32'h0000_F0F0, 5'b00001);
  endtask

  task automatic t_zero();
    run_op("R6 zero32", 0, 1, 0, 32'hCAFE_BABE, 32'h1234_5678, 5'b10101);
    run_op("R6 zero16", 1, 0, 0, 32'hCAFE_BABE, 32'h1234_5678, 5'b01010);
  endtask

  task automatic t_flags();
    run_op("R7 zero res", 0, 1, 8,  32'h0000_0000, 32'h00FF_FFFF, 5'b11111);
    run_op("R7 neg res",  1, 1, 1,  32'h0000_0000, 32'h0000_0001, 5'b00000);
    run_op("R7 odd par",  0, 0, 1,  32'h0000_0001, 32'h0000_0000, 5'b00000);
    run_op("R8 of set",   1, 0, 3,  32'h0000_1234, 32'h0000_0007, 5'b10000);
  endtask

  task automatic t_busy();
    logic [31:0] er;
    logic [4:0]  ef;
    model(0, 1, 4, 32'h0F0F_0F0F, 32'hF000_0000, 5'b00000, er, ef);
    @(negedge clk);
    start = 1'b1; shift_right = 0; wide = 1; count = 5'd4;
    dest = 32'h0F0F_0F0F; src = 32'hF000_0000; flags_in = 5'b00000;
    @(posedge clk);
    @(negedge clk);
    dest = 32'hFFFF_FFFF; src = 32'h0; count = 5'd9; shift_right = 1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    chk(done == 1'b1, "R10 busy done", 32'(done), 1);
    chk(result == er, "R10 busy result", result, er);
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chk(done == 1'b0 && result == er, "R10 no second op", result, er);
    end
  endtask

  initial begin
    #(PERIOD * 200000);
    if (!ended) begin
      errors++;
      $display("FAIL watchdog actual=%h expected=%h", 32'(0), 32'(1));
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_left32();
    t_right32();
    t_left16();
    t_right16();
    t_zero();
    t_flags();
    t_busy();
    ended = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule